// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the results of speculatively executed instructions until they can safely change machine state. Issue logic claims one slot per instruction, in program order, and receives the slot number. Execution units later report into that slot: the result value, an exception flag and a branch-mispredict flag. Store instructions also report their target address on a separate port. Retirement runs in order from the oldest slot. Only at retirement does a register write or a store release leave the block.

Exceptions and wrong branch predictions are only recorded when they are reported. They take effect when the faulting entry becomes the oldest one. At that point a single flush pulse discards every younger entry. For an exception, the faulting entry is discarded as well. Full and empty status lets the issue stage throttle itself.

Slot kinds use a two-bit code: 2'b00 register write, 2'b01 store, 2'b10 branch. The spare code 2'b11 behaves as a register write. DEPTH must be a power of two.

Top module: `spec_rob`

## Requirements
- R1: While `alloc_req` is high, `full` is low and `flush` is low, `alloc_grant` is high in the same cycle and the slot `alloc_idx` is claimed at the clock edge. After reset, granted slots are numbered 0, 1, 2, … modulo DEPTH. After a flush, numbering restarts at the oldest surviving position.
- R2: After reset `empty` is 1 and `full` is 0. `full` is 1 exactly when DEPTH slots are held, and no request is granted while it is 1.
- R3: A completion only records its value and flags in the slot. `rf_we`, `st_release` and `retire_valid` stay low for any slot that is not the oldest, even if that slot has completed.
- R4: At most one slot retires per cycle, always the oldest (`retire_idx`), and only when it has completed. A register-kind slot (code 00 or 11) drives `rf_we` with its destination on `rf_waddr` and its value on `rf_wdata`.
- R5: A store slot (code 01) retires only after both its data (completion port) and its address (`saddr_*` port) have arrived, in either order. It then raises `st_release` with `st_addr` and `st_data`, and never `rf_we`.
- R6: When the oldest slot has completed with its exception flag set, `exc_raise` and `flush` are high for that cycle. There is no register write, no store release and no `retire_valid`. All slots, including that one, are discarded, so `empty` is 1 in the next cycle.
- R7: A branch slot (code 10) that completed with its mispredict flag set raises `retire_valid` and `flush` when it retires, and all younger slots are discarded. A correctly predicted branch retires with no flush and no write.
- R8: A completion or store address aimed at a slot that is not held (for example, one just discarded) has no effect. A later instruction placed in that slot does not retire until it is itself completed.
- R9: No request is granted in a cycle where `flush` is high.
- R10: A completion to the oldest slot at one clock edge makes that slot retire in the cycle directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request a slot for the next instruction |
| alloc_kind | input | 2 | Slot kind: 00 register, 01 store, 10 branch, 11 register |
| alloc_dest | input | REGW | Destination register number |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_idx | output | IDXW | Slot number given to the request |
| cmpl_valid | input | 1 | Execution result report |
| cmpl_idx | input | IDXW | Slot the result belongs to |
| cmpl_value | input | DATAW | Result value (store data for stores) |
| cmpl_exc | input | 1 | Instruction raised an exception |
| cmpl_mispred | input | 1 | Branch prediction was wrong |
| saddr_valid | input | 1 | Store address report |
| saddr_idx | input | IDXW | Slot the address belongs to |
| saddr_value | input | ADDRW | Store address |
| retire_valid | output | 1 | Oldest slot retires normally this cycle |
| retire_idx | output | IDXW | Number of the oldest slot |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | REGW | Register file write address |
| rf_wdata | output | DATAW | Register file write data |
| st_release | output | 1 | Store may be performed |
| st_addr | output | ADDRW | Released store address |
| st_data | output | DATAW | Released store data |
| exc_raise | output | 1 | Exception taken at the oldest slot |
| flush | output | 1 | Discard younger speculative slots |
| full | output | 1 | All slots held |
| empty | output | 1 | No slot held |

## Verification
The embedded properties check on every cycle that:
- full and empty never coincide, and no grant is given while full;
- the occupancy moves by exactly the grants minus the retirements;
- a flush always leaves the buffer empty;
- a store release only happens with both halves present;
- the retirement outputs are mutually exclusive;
- a report to a slot that is not held leaves that slot's value alone.

Whether retirement follows program order, carries the right destination and data, and discards exactly the younger slots can only be shown by the bench. Its behavioural queue model compares every output on every cycle, across out-of-order completion, split store reports, exceptions arriving behind a wrong branch, and reports aimed at discarded slots.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Slot kind codes; decoded by retirement logic.
  localparam logic [1:0] KIND_REG    = 2'b00;
  localparam logic [1:0] KIND_STORE  = 2'b01;
  localparam logic [1:0] KIND_BRANCH = 2'b10;
  localparam logic [1:0] KIND_SPARE  = 2'b11;

  // A slot is ready once its result is in and, for stores, its address too.
  function automatic logic slot_ready(input logic held, input logic [1:0] kind,
                                      input logic vdone, input logic adone);
    return held && vdone && ((kind != KIND_STORE) || adone);
  endfunction

  // Register-write kinds: plain register and the spare code.
  function automatic logic writes_reg(input logic [1:0] kind);
    return (kind == KIND_REG) || (kind == KIND_SPARE);
  endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PW   = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            flush,
  output logic [IDXW-1:0] head_idx,
  output logic [IDXW-1:0] tail_idx,
  output logic            full,
  output logic            empty
);
  logic [PW-1:0] head_q, tail_q, head_nxt, count, cnt_exp;

  function automatic logic [PW-1:0] ptr_adv(input logic [PW-1:0] p, input logic step);
    return p + PW'(step);
  endfunction

  function automatic logic ptr_full(input logic [PW-1:0] h, input logic [PW-1:0] t);
    return (h[IDXW] != t[IDXW]) && (h[IDXW-1:0] == t[IDXW-1:0]);
  endfunction

  assign head_nxt = ptr_adv(head_q, pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_nxt;
      tail_q <= flush ? head_nxt : ptr_adv(tail_q, push);
    end
  end

  assign head_idx = head_q[IDXW-1:0];
  assign tail_idx = tail_q[IDXW-1:0];
  assign full     = ptr_full(head_q, tail_q);
  assign empty    = (head_q == tail_q);
  assign count    = tail_q - head_q;
  assign cnt_exp  = count + PW'(push) - PW'(pop);

  // R2: the status flags are mutually exclusive
  a_r2_full_xor_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R2: occupancy never exceeds the depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));

  // R1/R4: without a flush, occupancy moves by pushes minus pops
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && rst_n) |=> (count == $past(cnt_exp)));

  // R6/R7: a flush leaves nothing behind
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH = 8,
  parameter int REGW  = 5,
  parameter int DATAW = 32,
  parameter int ADDRW = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_en,
  input  logic [IDXW-1:0]  alloc_idx,
  input  logic [1:0]       alloc_kind,
  input  logic [REGW-1:0]  alloc_dest,
  input  logic             cmpl_en,
  input  logic [IDXW-1:0]  cmpl_idx,
  input  logic [DATAW-1:0] cmpl_value,
  input  logic             cmpl_exc,
  input  logic             cmpl_mis,
  input  logic             addr_en,
  input  logic [IDXW-1:0]  addr_idx,
  input  logic [ADDRW-1:0] addr_value,
  input  logic             clear_en,
  input  logic [IDXW-1:0]  head_idx,
  output logic             head_held,
  output logic [1:0]       head_kind,
  output logic [REGW-1:0]  head_dest,
  output logic [DATAW-1:0] head_value,
  output logic [ADDRW-1:0] head_addr,
  output logic             head_vdone,
  output logic             head_adone,
  output logic             head_exc,
  output logic             head_mis
);
  logic [DEPTH-1:0] held_v, vdone_v, adone_v, exc_v, mis_v;
  logic [1:0]       kind_a  [DEPTH];
  logic [REGW-1:0]  dest_a  [DEPTH];
  logic [DATAW-1:0] value_a [DEPTH];
  logic [ADDRW-1:0] addr_a  [DEPTH];

  // Events brought out for the checks below.
  logic cmpl_hit, addr_hit;
  assign cmpl_hit = cmpl_en && held_v[cmpl_idx];
  assign addr_hit = addr_en && held_v[addr_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             s_held, s_vdone, s_adone, s_exc, s_mis;
    logic [1:0]       s_kind;
    logic [REGW-1:0]  s_dest;
    logic [DATAW-1:0] s_value;
    logic [ADDRW-1:0] s_addr;
    logic             hit_alloc, hit_cmpl, hit_addr, hit_clear;

    assign hit_alloc = alloc_en && (alloc_idx == IDXW'(i));
    assign hit_cmpl  = cmpl_en && (cmpl_idx == IDXW'(i)) && s_held;
    assign hit_addr  = addr_en && (addr_idx == IDXW'(i)) && s_held;
    assign hit_clear = clear_en && (head_idx == IDXW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_held  <= 1'b0;
        s_vdone <= 1'b0;
        s_adone <= 1'b0;
        s_exc   <= 1'b0;
        s_mis   <= 1'b0;
        s_kind  <= '0;
        s_dest  <= '0;
        s_value <= '0;
        s_addr  <= '0;
      end else if (flush) begin
        s_held <= 1'b0;
      end else if (hit_alloc) begin
        s_held  <= 1'b1;
        s_kind  <= alloc_kind;
        s_dest  <= alloc_dest;
        s_vdone <= 1'b0;
        s_adone <= 1'b0;
        s_exc   <= 1'b0;
        s_mis   <= 1'b0;
      end else begin
        if (hit_clear) s_held <= 1'b0;
        if (hit_cmpl) begin
          s_value <= cmpl_value;
          s_vdone <= 1'b1;
          s_exc   <= cmpl_exc;
          s_mis   <= cmpl_mis;
        end
        if (hit_addr) begin
          s_addr  <= addr_value;
          s_adone <= 1'b1;
        end
      end
    end

    assign held_v[i]  = s_held;
    assign vdone_v[i] = s_vdone;
    assign adone_v[i] = s_adone;
    assign exc_v[i]   = s_exc;
    assign mis_v[i]   = s_mis;
    assign kind_a[i]  = s_kind;
    assign dest_a[i]  = s_dest;
    assign value_a[i] = s_value;
    assign addr_a[i]  = s_addr;
  end

  assign head_held  = held_v[head_idx];
  assign head_kind  = kind_a[head_idx];
  assign head_dest  = dest_a[head_idx];
  assign head_value = value_a[head_idx];
  assign head_addr  = addr_a[head_idx];
  assign head_vdone = vdone_v[head_idx];
  assign head_adone = adone_v[head_idx];
  assign head_exc   = exc_v[head_idx];
  assign head_mis   = mis_v[head_idx];

  // R8: a result aimed at a slot that is not held leaves it untouched
  a_r8_stale_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_en && !cmpl_hit) |=> (value_a[$past(cmpl_idx)] == $past(value_a[cmpl_idx])));

  // R8: same for a store address aimed at a slot that is not held
  a_r8_stale_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && !addr_hit) |=> (addr_a[$past(addr_idx)] == $past(addr_a[addr_idx])));

  // R1: a fresh claim starts without a result
  a_r1_fresh_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !flush) |=> (held_v[$past(alloc_idx)] && !vdone_v[$past(alloc_idx)]));
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
  parameter int REGW  = 5,
  parameter int DATAW = 32,
  parameter int ADDRW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_held,
  input  logic [1:0]       head_kind,
  input  logic [REGW-1:0]  head_dest,
  input  logic [DATAW-1:0] head_value,
  input  logic [ADDRW-1:0] head_addr,
  input  logic             head_vdone,
  input  logic             head_adone,
  input  logic             head_exc,
  input  logic             head_mis,
  output logic             retire,
  output logic             take_exc,
  output logic             kill,
  output logic             rf_we,
  output logic [REGW-1:0]  rf_waddr,
  output logic [DATAW-1:0] rf_wdata,
  output logic             st_release,
  output logic [ADDRW-1:0] st_addr,
  output logic [DATAW-1:0] st_data
);
  import rob_pkg::*;

  logic ready, wrong_branch;

  assign ready        = slot_ready(head_held, head_kind, head_vdone, head_adone);
  assign take_exc     = ready && head_exc;
  assign retire       = ready && !head_exc;
  assign wrong_branch = retire && (head_kind == KIND_BRANCH) && head_mis;
  assign kill         = take_exc || wrong_branch;

  assign rf_we      = retire && writes_reg(head_kind);
  assign rf_waddr   = head_dest;
  assign rf_wdata   = head_value;
  assign st_release = retire && (head_kind == KIND_STORE);
  assign st_addr    = head_addr;
  assign st_data    = head_value;

  // R5: a store leaves only with both halves present
  a_r5_store_complete: assert property (@(posedge clk) disable iff (!rst_n)
    st_release |-> (head_vdone && head_adone));

  // R3/R4/R6: at most one retirement action per cycle
  a_r4_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, st_release, take_exc}));

  // R6: an exception always discards and never writes
  a_r6_exc_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> (kill && !retire));

  // R3: no architectural write from an unfinished or empty slot
  a_r3_write_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || st_release) |-> (head_held && head_vdone));
endmodule

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int DEPTH = 8,
  parameter int REGW  = 5,
  parameter int DATAW = 32,
  parameter int ADDRW = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic [1:0]       alloc_kind,
  input  logic [REGW-1:0]  alloc_dest,
  output logic             alloc_grant,
  output logic [IDXW-1:0]  alloc_idx,
  input  logic             cmpl_valid,
  input  logic [IDXW-1:0]  cmpl_idx,
  input  logic [DATAW-1:0] cmpl_value,
  input  logic             cmpl_exc,
  input  logic             cmpl_mispred,
  input  logic             saddr_valid,
  input  logic [IDXW-1:0]  saddr_idx,
  input  logic [ADDRW-1:0] saddr_value,
  output logic             retire_valid,
  output logic [IDXW-1:0]  retire_idx,
  output logic             rf_we,
  output logic [REGW-1:0]  rf_waddr,
  output logic [DATAW-1:0] rf_wdata,
  output logic             st_release,
  output logic [ADDRW-1:0] st_addr,
  output logic [DATAW-1:0] st_data,
  output logic             exc_raise,
  output logic             flush,
  output logic             full,
  output logic             empty
);
  logic [IDXW-1:0]  head_idx, tail_idx;
  logic             head_held, head_vdone, head_adone, head_exc, head_mis;
  logic [1:0]       head_kind;
  logic [REGW-1:0]  head_dest;
  logic [DATAW-1:0] head_value;
  logic [ADDRW-1:0] head_addr;
  logic             retire, kill;

  assign alloc_grant  = alloc_req && !full && !flush;
  assign alloc_idx    = tail_idx;
  assign retire_valid = retire;
  assign retire_idx   = head_idx;
  assign flush        = kill;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(alloc_grant), .pop(retire), .flush(kill),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full), .empty(empty)
  );

  rob_entries #(.DEPTH(DEPTH), .REGW(REGW), .DATAW(DATAW), .ADDRW(ADDRW)) u_entries (
    .clk(clk), .rst_n(rst_n), .flush(kill),
    .alloc_en(alloc_grant), .alloc_idx(tail_idx), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest),
    .cmpl_en(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_value(cmpl_value),
    .cmpl_exc(cmpl_exc), .cmpl_mis(cmpl_mispred),
    .addr_en(saddr_valid), .addr_idx(saddr_idx), .addr_value(saddr_value),
    .clear_en(retire), .head_idx(head_idx),
    .head_held(head_held), .head_kind(head_kind), .head_dest(head_dest),
    .head_value(head_value), .head_addr(head_addr), .head_vdone(head_vdone),
    .head_adone(head_adone), .head_exc(head_exc), .head_mis(head_mis)
  );

  rob_retire #(.REGW(REGW), .DATAW(DATAW), .ADDRW(ADDRW)) u_retire (
    .clk(clk), .rst_n(rst_n),
    .head_held(head_held), .head_kind(head_kind), .head_dest(head_dest),
    .head_value(head_value), .head_addr(head_addr), .head_vdone(head_vdone),
    .head_adone(head_adone), .head_exc(head_exc), .head_mis(head_mis),
    .retire(retire), .take_exc(exc_raise), .kill(kill),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .st_release(st_release), .st_addr(st_addr), .st_data(st_data)
  );

  // R9: never grant in a flush cycle
  a_r9_no_grant_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_grant);

  // R2: never grant while full
  a_r2_no_grant_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_grant);

  // R4: retirement and exception exclude each other
  a_r4_retire_or_exc: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_valid && exc_raise));
endmodule

// File: tb/test_spec_rob.sv
module test_spec_rob;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int IDXW  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_req = 0;
  logic [1:0]  a_kind = 0;
  logic [4:0]  a_dest = 0;
  logic        c_v = 0, c_exc = 0, c_mis = 0;
  logic [IDXW-1:0] c_idx = 0;
  logic [31:0] c_val = 0;
  logic        s_v = 0;
  logic [IDXW-1:0] s_idx = 0;
  logic [31:0] s_addr = 0;

  logic alloc_grant, retire_valid, rf_we, st_release, exc_raise, flush, full, empty;
  logic [IDXW-1:0] alloc_idx, retire_idx;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata, st_addr, st_data;

  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_rob i_spec_rob (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(a_req), .alloc_kind(a_kind), .alloc_dest(a_dest),
    .alloc_grant(alloc_grant), .alloc_idx(alloc_idx),
    .cmpl_valid(c_v), .cmpl_idx(c_idx), .cmpl_value(c_val),
    .cmpl_exc(c_exc), .cmpl_mispred(c_mis),
    .saddr_valid(s_v), .saddr_idx(s_idx), .saddr_value(s_addr),
    .retire_valid(retire_valid), .retire_idx(retire_idx),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .st_release(st_release), .st_addr(st_addr), .st_data(st_data),
    .exc_raise(exc_raise), .flush(flush), .full(full), .empty(empty)
  );

  // Behavioural model: a queue of in-flight instructions, oldest first.
  typedef struct {
    int idx; int kind; int dest; logic [31:0] val; logic [31:0] addr;
    bit exc; bit mis; bit vd; bit ad;
  } ent_t;
  ent_t q[$];
  int hc = 0, tc = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    a_req = 0; c_v = 0; c_exc = 0; c_mis = 0; s_v = 0;
  endtask

  // Compare all outputs against the model, then advance the model and clock.
  task automatic tick();
    bit hv, rdy, e_exc, e_ret, e_flush, e_rf, e_st, e_full, e_grant;
    int k;
    #1;
    hv = q.size() > 0;
    k = hv ? q[0].kind : 0;
    rdy = hv && q[0].vd && (k != 1 || q[0].ad);
    e_exc = rdy && q[0].exc;
    e_ret = rdy && !q[0].exc;
    e_flush = e_exc || (e_ret && k == 2 && q[0].mis);
    e_rf = e_ret && (k == 0 || k == 3);
    e_st = e_ret && k == 1;
    e_full = q.size() == DEPTH;
    e_grant = a_req && !e_full && !e_flush;
    chk(e_flush && a_req ? "R9" : "R1", "alloc_grant", 64'(alloc_grant), 64'(e_grant));
    chk("R1", "alloc_idx", 64'(alloc_idx), 64'(tc % DEPTH));
    chk("R2", "full", 64'(full), 64'(e_full));
    chk("R2", "empty", 64'(empty), 64'(q.size() == 0));
    chk("R3", "rf_we", 64'(rf_we), 64'(e_rf));
    chk("R10", "retire_valid", 64'(retire_valid), 64'(e_ret));
    chk("R5", "st_release", 64'(st_release), 64'(e_st));
    chk("R6", "exc_raise", 64'(exc_raise), 64'(e_exc));
    chk("R7", "flush", 64'(flush), 64'(e_flush));
    if (hv) chk("R4", "retire_idx", 64'(retire_idx), 64'(q[0].idx));
    if (e_rf) begin
      chk("R4", "rf_waddr", 64'(rf_waddr), 64'(q[0].dest));
      chk("R4", "rf_wdata", 64'(rf_wdata), 64'(q[0].val));
    end
    if (e_st) begin
      chk("R5", "st_addr", 64'(st_addr), 64'(q[0].addr));
      chk("R5", "st_data", 64'(st_data), 64'(q[0].val));
    end
    // R8: reports only land on held slots
    foreach (q[i]) begin
      if (c_v && q[i].idx == int'(c_idx)) begin
        q[i].val = c_val; q[i].exc = c_exc; q[i].mis = c_mis; q[i].vd = 1;
      end
      if (s_v && q[i].idx == int'(s_idx)) begin
        q[i].addr = s_addr; q[i].ad = 1;
      end
    end
    if (e_exc) begin
      q.delete(); tc = hc;
    end else if (e_ret) begin
      void'(q.pop_front()); hc = (hc + 1) % (2 * DEPTH);
      if (e_flush) begin q.delete(); tc = hc; end
    end
    if (e_grant) begin
      ent_t n;
      n.idx = tc % DEPTH; n.kind = int'(a_kind); n.dest = int'(a_dest);
      n.val = 0; n.addr = 0; n.exc = 0; n.mis = 0; n.vd = 0; n.ad = 0;
      q.push_back(n);
      tc = (tc + 1) % (2 * DEPTH);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_alloc(logic [1:0] kind, logic [4:0] dest);
    idle(); a_req = 1; a_kind = kind; a_dest = dest; tick(); idle();
  endtask

  task automatic do_cmpl(int idx, logic [31:0] v, bit e, bit m);
    idle(); c_v = 1; c_idx = IDXW'(idx); c_val = v; c_exc = e; c_mis = m; tick(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2", "empty after reset", 64'(empty), 64'd1);
    chk("R2", "full after reset", 64'(full), 64'd0);
    rst_n = 1;

    // R1/R2: fill beyond capacity, then R3/R4: complete out of order
    for (int i = 0; i < DEPTH + 1; i++) do_alloc(2'b00, 5'(i + 1));
    foreach (q[i]) begin end
    do_cmpl(7, 32'h70, 0, 0); do_cmpl(3, 32'h30, 0, 0); do_cmpl(5, 32'h50, 0, 0);
    do_cmpl(0, 32'h00, 0, 0); do_cmpl(1, 32'h10, 0, 0); do_cmpl(2, 32'h20, 0, 0);
    do_cmpl(4, 32'h40, 0, 0); do_cmpl(6, 32'h60, 0, 0);
    repeat (10) tick();

    // R5: store with data first, address later
    base = tc % DEPTH;
    do_alloc(2'b01, 5'd0);
    do_cmpl(base, 32'hDA7A, 0, 0);
    repeat (2) tick();
    idle(); s_v = 1; s_idx = IDXW'(base); s_addr = 32'hADD0; tick(); idle();
    repeat (2) tick();

    // R6/R8/R9: exception behind a good instruction
    base = tc % DEPTH;
    for (int i = 0; i < 4; i++) do_alloc(2'b00, 5'(10 + i));
    do_cmpl((base + 1) % DEPTH, 32'hBAD, 1, 0);
    do_cmpl(base, 32'h600D, 0, 0);
    tick();                        // oldest retires
    idle(); a_req = 1; tick(); idle();   // R9: request during the flush cycle
    do_cmpl((base + 2) % DEPTH, 32'h5A1E, 0, 0); // R8: stale report
    do_alloc(2'b00, 5'd20); do_alloc(2'b00, 5'd21);
    for (int i = 0; i < 3; i++) begin
      #1; chk("R8", "stale slot stays unretired", 64'(retire_valid), 64'd0);
      tick();
    end
    do_cmpl((base + 1) % DEPTH, 32'h11, 0, 0);
    do_cmpl((base + 2) % DEPTH, 32'h22, 0, 0);
    repeat (3) tick();

    // R7: wrong branch with completed younger ones, then a correct branch
    base = tc % DEPTH;
    do_alloc(2'b10, 5'd0); do_alloc(2'b00, 5'd7); do_alloc(2'b00, 5'd8);
    do_cmpl((base + 1) % DEPTH, 32'h77, 0, 0);
    do_cmpl((base + 2) % DEPTH, 32'h88, 0, 0);
    do_cmpl(base, 32'h0, 0, 1);
    repeat (2) tick();
    base = tc % DEPTH;
    do_alloc(2'b10, 5'd0); do_alloc(2'b11, 5'd9);
    do_cmpl((base + 1) % DEPTH, 32'h99, 0, 0);
    do_cmpl(base, 32'h0, 0, 0);
    repeat (3) tick();

    // R10: completion at one edge retires in the next cycle
    base = tc % DEPTH;
    do_alloc(2'b00, 5'd3);
    tick();
    do_cmpl(base, 32'h1234, 0, 0);
    #1; chk("R10", "retire right after completion", 64'(retire_valid), 64'd1);
    tick();

    // Mixed random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      idle();
      a_req  = ($urandom % 2) == 0;
      a_kind = 2'($urandom);
      a_dest = 5'($urandom);
      c_v    = ($urandom % 5) < 3;
      c_idx  = IDXW'($urandom);
      c_val  = $urandom;
      c_exc  = ($urandom % 25) == 0;
      c_mis  = ($urandom % 5) == 0;
      s_v    = ($urandom % 2) == 0;
      s_idx  = IDXW'($urandom);
      s_addr = $urandom;
      tick();
    end
    idle();
    repeat (4) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule